// File: doc/BRIEF.md
# Multi-format stereo audio serial receiver

This block turns a serial stereo audio stream into pairs of 24-bit two's-complement samples. The stream is carried on three external wires: a bit clock, a frame clock that marks the left and right halves of each frame, and one data line. A faster system clock samples all three wires through a synchroniser, and the block finds bit-clock rising edges in that domain. On each such edge the block shifts one data bit into a single 24-bit window, most significant bit first.

A 3-bit format input selects how the word sits inside each half frame. In left-justified mode the word starts right at the frame-clock transition. In I2S mode it starts one bit later. In the right-justified modes the word ends on the last bit of the half frame. Each completed left and right pair is presented on two parallel outputs together with a one-cycle valid strobe. The outputs then hold until the next pair.

Top module: `aud_serial_rx`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `left_o` and `right_o` read 0 and `valid_o` is low.
- R2: Bits are sampled on rising bit-clock edges, MSB first. With `fmt_i` = 3'b010 (left-justified 24-bit), the word occupies the 24 bits that start at the first bit after a frame-clock change. Frame clock high marks the left channel.
- R3: With `fmt_i` = 3'b011 (I2S 24-bit), the MSB comes one bit after the frame-clock change, and frame clock low marks the left channel. When a half frame is exactly 24 bits long, the LSB falls on the first bit of the following half, and the word is still captured whole.
- R4: With `fmt_i` = 3'b100 (right-justified 24-bit), the word is the last 24 bits of each half frame. Frame clock high marks the left channel.
- R5: With `fmt_i` = 3'b001 (right-justified 20-bit), the word is the last 20 bits of each half frame. It is presented in output bits 23:4, and bits 3:0 are zero.
- R6: With `fmt_i` = 3'b000 (right-justified 16-bit), the word is the last 16 bits of each half frame. It is presented in output bits 23:8, and bits 7:0 are zero.
- R7: Bits that fall outside the selected word position in a half frame have no effect on the presented samples.
- R8: `valid_o` pulses for exactly one cycle per frame, once the right channel of that frame has been captured. It carries that frame's left and right words. `left_o` and `right_o` do not change in any cycle without a pulse.
- R9: The block decodes frames at the minimum bit-clock ratios: 32 bits per frame for 3'b000, 40 for 3'b001 and 48 for the 24-bit formats.
- R10: The in-half bit position restarts at every frame-clock change, so left and right halves of unequal length decode correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | External serial bit clock (asynchronous) |
| frame_i | input | 1 | External left/right frame clock (asynchronous) |
| sdata_i | input | 1 | External serial data line (asynchronous) |
| fmt_i | input | 3 | Framing format select |
| left_o | output | 24 | Most recent left sample, left-aligned |
| right_o | output | 24 | Most recent right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe when a new sample pair is presented |

## Verification
In three cases a frame-clock change and a word capture happen on the same bit-clock edge. In the right-justified modes the previous half's word must be taken before the new bit enters the window. In I2S mode a 24-bit half frame pushes its LSB onto the first bit of the next half. In those same cycles the position counter restarts. The bench provokes these cases with streams at exactly 48, 40 and 32 bits per frame, and with halves of unequal length. It judges them by comparing every presented pair with the transmitted samples, which are chosen so that their MSB and LSB differ from the neighbouring words.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int WORD16_W = 16;
    localparam int WORD20_W = 20;

    typedef enum logic [2:0] {
        FMT_RJ16  = 3'b000,
        FMT_RJ20  = 3'b001,
        FMT_LJ24  = 3'b010,
        FMT_I2S24 = 3'b011,
        FMT_RJ24  = 3'b100
    } aud_fmt_e;

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/aud_rx_edge.sv
module aud_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);

    logic prev_d, prev_q;

    always_comb prev_d = lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise_o = lvl_i & ~prev_q;

    // R2: a bit-clock rise is seen for a single system cycle only
    assert_rise_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
    import aud_rx_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_rise_i,
    input  logic                lr_i,
    input  logic                data_i,
    input  logic [2:0]          fmt_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SAMPLE_W - 1);
    localparam logic [CNT_W-1:0] I2S_IDX  = CNT_W'(SAMPLE_W);
    localparam int               SH16     = SAMPLE_W - WORD16_W;
    localparam int               SH20     = SAMPLE_W - WORD20_W;

    typedef struct packed {
        logic [SAMPLE_W-1:0] shreg;
        logic [CNT_W-1:0]    cnt;
        logic                prev_lr;
        logic                synced;
        logic                have_left;
        logic [SAMPLE_W-1:0] left_hold;
        logic [SAMPLE_W-1:0] left_out;
        logic [SAMPLE_W-1:0] right_out;
        logic                valid;
    } st_t;

    st_t d, q;

    logic                frame_edge;
    logic                i2s_spill;
    logic                cap;
    logic                cap_left;
    logic [CNT_W-1:0]    idx;
    logic [SAMPLE_W-1:0] shifted;
    logic [SAMPLE_W-1:0] word;

    always_comb begin
        d          = q;
        d.valid    = 1'b0;
        frame_edge = (lr_i != q.prev_lr);
        idx        = frame_edge ? '0 : ((q.cnt == CNT_MAX) ? q.cnt : q.cnt + 1'b1);
        shifted    = {q.shreg[SAMPLE_W-2:0], data_i};
        i2s_spill  = frame_edge && q.synced && (q.cnt == LAST_IDX);
        cap        = 1'b0;
        cap_left   = 1'b0;
        word       = shifted;

        case (fmt_i)
            FMT_I2S24: begin
                cap      = i2s_spill || (!frame_edge && q.synced && (idx == I2S_IDX));
                cap_left = i2s_spill ? !q.prev_lr : !lr_i;
            end
            FMT_RJ16: begin
                cap      = frame_edge && q.synced;
                cap_left = q.prev_lr;
                word     = q.shreg << SH16;
            end
            FMT_RJ20: begin
                cap      = frame_edge && q.synced;
                cap_left = q.prev_lr;
                word     = q.shreg << SH20;
            end
            FMT_RJ24: begin
                cap      = frame_edge && q.synced;
                cap_left = q.prev_lr;
                word     = q.shreg;
            end
            default: begin
                cap      = q.synced && (idx == LAST_IDX);
                cap_left = lr_i;
            end
        endcase

        if (bit_rise_i) begin
            d.cnt     = idx;
            d.prev_lr = lr_i;
            d.shreg   = shifted;
            if (frame_edge) d.synced = 1'b1;
            if (cap) begin
                if (cap_left) begin
                    d.left_hold = word;
                    d.have_left = 1'b1;
                end else if (q.have_left) begin
                    d.left_out  = q.left_hold;
                    d.right_out = word;
                    d.valid     = 1'b1;
                    d.have_left = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign left_o  = q.left_out;
    assign right_o = q.right_out;
    assign valid_o = q.valid;

    // R8: the strobe is a single-cycle pulse
    assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |=> !q.valid);

    // R8: a pair is only presented as the result of a bit-clock rise
    assert_valid_on_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |-> $past(bit_rise_i));

    // R8: outputs hold whenever no pair is presented
    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !q.valid |-> ($stable(q.left_out) && $stable(q.right_out)));

    // R10: position restarts on every frame-clock change
    assert_cnt_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_rise_i && (lr_i != q.prev_lr)) |=> (q.cnt == '0));

    // R6: 16-bit words leave the low output bits clear
    assert_rj16_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && ($past(fmt_i) == FMT_RJ16)) |-> (q.right_out[SH16-1:0] == '0));

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
    import aud_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_i,
    input  logic                frame_i,
    input  logic                sdata_i,
    input  logic [2:0]          fmt_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);

    localparam int LINES = 3;

    logic [LINES-1:0] lines_sync;
    logic             bit_rise;

    aud_rx_sync #(
        .W      (LINES),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({bclk_i, frame_i, sdata_i}),
        .sync_o  (lines_sync)
    );

    aud_rx_edge edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lines_sync[2]),
        .rise_o (bit_rise)
    );

    aud_rx_deser #(
        .CNT_W (CNT_W)
    ) deser_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_rise_i (bit_rise),
        .lr_i       (lines_sync[1]),
        .data_i     (lines_sync[0]),
        .fmt_i      (fmt_i),
        .left_o     (left_o),
        .right_o    (right_o),
        .valid_o    (valid_o)
    );

endmodule

// File: tb/aud_serial_rx_tb.sv
module aud_serial_rx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;
    localparam int WATCHDOG   = 150000;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk  = 1'b0;
    logic        frame = 1'b0;
    logic        sdata = 1'b0;
    logic [2:0]  fmt   = 3'b010;
    logic [23:0] left_o, right_o;
    logic        valid_o;

    int n_checks = 0;
    int n_fail   = 0;
    int nv       = 0;
    int width_err = 0;
    int hold_err  = 0;
    logic [23:0] cap_l [64];
    logic [23:0] cap_r [64];
    logic        prev_v = 1'b0;
    logic [23:0] last_l = '0, last_r = '0;
    logic        i2s_lag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aud_serial_rx dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk_i  (bclk),
        .frame_i (frame),
        .sdata_i (sdata),
        .fmt_i   (fmt),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o)
    );

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid_o) begin
                cap_l[nv % 64] = left_o;
                cap_r[nv % 64] = right_o;
                nv = nv + 1;
                if (prev_v) width_err = width_err + 1;
            end else if (left_o != last_l || right_o != last_r) begin
                hold_err = hold_err + 1;
            end
        end
        prev_v = valid_o;
        last_l = left_o;
        last_r = right_o;
    end

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] smp(input int k, input int ch);
        logic [23:0] v;
        v = 24'h5A3C96 ^ (24'(k) * 24'h13579B) ^ (ch != 0 ? 24'hC3A5E1 : 24'h0);
        if (k % 2 == 1) v[23] = ~v[23];
        v[0] = (k + ch) % 2 == 0;
        return v;
    endfunction

    function automatic int word_w(input logic [2:0] f);
        return (f == 3'b000) ? 16 : (f == 3'b001) ? 20 : 24;
    endfunction

    function automatic logic [23:0] expect_word(input logic [2:0] f, input logic [23:0] s);
        if (f == 3'b000) return {s[23:8], 8'h00};
        if (f == 3'b001) return {s[23:4], 4'h0};
        return s;
    endfunction

    function automatic logic junk(input int jm, input int i);
        if (jm == 0) return 1'b0;
        if (jm == 1) return 1'b1;
        return 1'(i % 2) ^ 1'((i / 4) % 2);
    endfunction

    // Bit value at position i of a half frame of length len (before the I2S delay)
    function automatic logic stream_bit(input logic [2:0] f, input logic [23:0] s,
                                        input int i, input int len, input int jm);
        int w;
        int p;
        w = word_w(f);
        if (f == 3'b010 || f == 3'b011) begin
            return (i < 24) ? s[23-i] : junk(jm, i);
        end
        p = len - 1 - i;
        return (p < w) ? s[24-w+p] : junk(jm, i);
    endfunction

    task automatic drive_bit(input logic lvl, input logic b);
        @(negedge clk);
        bclk  = 1'b0;
        frame = lvl;
        sdata = b;
        repeat (HALF_BIT) @(negedge clk);
        bclk = 1'b1;
        repeat (HALF_BIT - 1) @(negedge clk);
    endtask

    task automatic send(input logic lvl, input logic b);
        if (fmt == 3'b011) begin
            drive_bit(lvl, i2s_lag);
            i2s_lag = b;
        end else begin
            drive_bit(lvl, b);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bclk  = 1'b0;
        frame = 1'b0;
        sdata = 1'b0;
        i2s_lag = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Streams nfr frames and checks every presented pair
    task automatic run_stream(input string req, input logic [2:0] f, input int lh,
                              input int rh, input int jm, input int nfr);
        int   base;
        logic ll;
        fmt = f;
        do_reset();
        base = nv;
        ll = (f == 3'b011) ? 1'b0 : 1'b1;
        for (int i = 0; i < 8; i++) send(!ll, junk(jm, i));
        for (int k = 0; k < nfr; k++) begin
            for (int i = 0; i < lh; i++) send(ll, stream_bit(f, smp(k, 0), i, lh, jm));
            for (int i = 0; i < rh; i++) send(!ll, stream_bit(f, smp(k, 1), i, rh, jm));
        end
        for (int i = 0; i < 8; i++) send(ll, junk(jm, i));
        repeat (12) @(negedge clk);
        check({req, " pair count"}, 24'(nv - base), 24'(nfr));
        for (int k = 0; k < nfr; k++) begin
            check({req, " left"},  cap_l[(base + k) % 64], expect_word(f, smp(k, 0)));
            check({req, " right"}, cap_r[(base + k) % 64], expect_word(f, smp(k, 1)));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 left during reset", left_o, 24'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 left after reset", left_o, 24'h0);
        check("R1 right after reset", right_o, 24'h0);
        check("R1 valid after reset", 24'(valid_o), 24'h0);
    endtask

    task automatic t_left_justified();
        run_stream("R2 lj 64fs", 3'b010, 32, 32, 0, 3);
    endtask

    task automatic t_i2s();
        run_stream("R3 i2s 64fs", 3'b011, 32, 32, 2, 3);
        run_stream("R3 R9 i2s 48fs spill", 3'b011, 24, 24, 0, 3);
    endtask

    task automatic t_rj24();
        run_stream("R4 rj24 64fs", 3'b100, 32, 32, 0, 3);
        run_stream("R9 rj24 48fs", 3'b100, 24, 24, 0, 3);
    endtask

    task automatic t_rj20();
        run_stream("R5 rj20 64fs", 3'b001, 32, 32, 0, 3);
        run_stream("R5 R9 rj20 40fs", 3'b001, 20, 20, 0, 3);
    endtask

    task automatic t_rj16();
        run_stream("R6 rj16 64fs", 3'b000, 32, 32, 0, 3);
        run_stream("R6 R9 rj16 32fs", 3'b000, 16, 16, 0, 3);
    endtask

    task automatic t_min_lj();
        run_stream("R9 lj 48fs", 3'b010, 24, 24, 0, 3);
    endtask

    task automatic t_ignored_bits();
        run_stream("R7 lj ones filler", 3'b010, 32, 32, 1, 2);
        run_stream("R7 rj16 ones filler", 3'b000, 32, 32, 1, 2);
        run_stream("R7 rj20 mixed filler", 3'b001, 32, 32, 2, 2);
    endtask

    task automatic t_unequal();
        run_stream("R10 lj unequal", 3'b010, 30, 26, 2, 3);
        run_stream("R10 rj24 unequal", 3'b100, 27, 31, 2, 3);
    endtask

    task automatic t_strobe();
        check("R8 valid width", 24'(width_err), 24'h0);
        check("R8 output hold", 24'(hold_err), 24'h0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=finish", WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_left_justified();
        t_i2s();
        t_rj24();
        t_rj20();
        t_rj16();
        t_min_lj();
        t_ignored_bits();
        t_unequal();
        t_strobe();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule